// File: doc/BRIEF.md
# Serial Management Frame Decoder with PHY Register Store

This block turns a software-driven, bit-banged management interface into register accesses on a small model of a PHY. Software writes a 32-bit control word. Three of its bits act as the management clock, the outgoing data bit and a direction flag. A fourth bit returns incoming data. Each rising edge of the software clock bit shifts one bit into a 32-bit frame word, and a bit counter keeps track of the position within the frame.

Frames are decoded at fixed counts. Sixteen clocks after a preamble, a read command loads the addressed 16-bit register into the frame word. From then on, while the direction flag is set, that data comes back one bit per clock on the return bit. At thirty-two clocks, a write command stores its 16-bit data field. The register store holds 32 words with fixed reset values, and it answers only at management address 1.

Top module: `mgmt_bitbang_phy`

## Requirements
- R1: After reset the control readback is all zeros. One cycle after a write, every readback bit except bit 19 equals the written bit.
- R2: Bit 19 of a write is ignored. The return bit changes only through the frame logic, and the readback holds while no write occurs.
- R3: Only a write whose bit 16 is 1 while the stored bit 16 is 0 is a clock step. Any other write leaves the bit counter, the frame word and the return bit unchanged.
- R4: On a step, bit 17 is shifted in at the LSB if the new count is below 16 or bit 18 is 0. Otherwise a 0 is shifted in.
- R5: When the frame word becomes all ones after a shift, the counter returns to 0 and no decode takes place.
- R6: When the count reaches 16, a read command is decoded: bits 15:12 equal 4'b0110, bits 11:7 hold the address and bits 6:2 hold the register. The frame word is then replaced by that register's value.
- R7: On a step with new count of 16 or more and bit 18 set, the return bit takes bit 15 of the shifted word. For a read, the return bit after the k-th clock of the frame (17 ≤ k ≤ 31) equals register bit 31−k. After clock 16 it is 0.
- R8: When the count reaches 32, a write command is decoded: bits 31:28 equal 4'b0101, bits 27:23 hold the address, bits 22:18 hold the register and bits 15:0 hold the data. The data is then stored.
- R9: Only address 1 responds. A read at any other address loads zero, and a write to any other address changes nothing.
- R10: Reset values of the register store are: reg0 0x3100, reg1 0xF02C, reg2 0x7810, reg4 0x0501, reg5 0x4181, reg14 0x3800, reg16 0x0003, reg17 0x0600, reg18 0x0001. All other registers reset to 0.
- R11: The counter saturates at 32. Clocks after that decode nothing until a preamble resets the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word: bit 16 clock, bit 17 data out, bit 18 direction |
| rd_data | output | 32 | Control readback; bit 19 is the return data bit |

## Verification
The assertions check every cycle that written bits appear in the readback one cycle later. They also check that the readback holds while no write occurs, that a write without a rising clock bit leaves the counter and the return bit unchanged, that the return bit never moves while the direction flag is clear, and that the counter never passes 32. Only the bench's scenarios can show frame-level behaviour. That covers register data returned serially, writes landing in the store, the reset values, writes to the wrong address being ignored, data bits dropped when the direction flag is set during a write, and a second unframed command after saturation having no effect. A behavioural model in the bench is compared with the readback on every cycle.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int CTRL_W   = 32;
  localparam int MDC_BIT  = 16;
  localparam int MDO_BIT  = 17;
  localparam int DIR_BIT  = 18;
  localparam int MDI_BIT  = 19;
  localparam int FRAME_W  = 32;
  localparam int HALF_CNT = 16;
  localparam int REG_W    = 16;
  localparam int REG_N    = 32;
  localparam int ADDR_W   = 5;
  localparam int OP_W     = 4;
  localparam int RD_OP_LSB  = 12;
  localparam int RD_PHY_LSB = 7;
  localparam int RD_REG_LSB = 2;
  localparam int WR_OP_LSB  = 28;
  localparam int WR_PHY_LSB = 23;
  localparam int WR_REG_LSB = 18;

  function automatic logic [REG_W-1:0] phy_reset_value(input int idx);
    case (idx)
      0:       return 16'h3100;
      1:       return 16'hF02C;
      2:       return 16'h7810;
      4:       return 16'h0501;
      5:       return 16'h4181;
      14:      return 16'h3800;
      16:      return 16'h0003;
      17:      return 16'h0600;
      18:      return 16'h0001;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/mgmt_ctrl_reg.sv
module mgmt_ctrl_reg
  import mgmt_pkg::*;
#(
  parameter int CW   = CTRL_W,
  parameter int MDC  = MDC_BIT,
  parameter int MDO  = MDO_BIT,
  parameter int DIR  = DIR_BIT,
  parameter int MDI  = MDI_BIT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] ctrl_q,
  output logic          step,
  output logic          mdo,
  output logic          dir
);
  localparam logic [CW-1:0] KEEP_MASK = ~(CW'(1) << MDI);

  // a step is a write that raises the clock bit
  assign step = wr_en & wr_data[MDC] & ~ctrl_q[MDC];
  assign mdo  = wr_data[MDO];
  assign dir  = wr_data[DIR];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q <= wr_data & KEEP_MASK;
    end
  end
endmodule

// File: rtl/mgmt_phy_regfile.sv
module mgmt_phy_regfile
  import mgmt_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int RN = REG_N,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] raddr,
  output logic [RW-1:0] rdata,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [RW-1:0] wdata
);
  logic [RW-1:0] mem [RN];

  assign rdata = mem[raddr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < RN; i++) begin
        mem[i] <= phy_reset_value(i);
      end
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end
endmodule

// File: rtl/mgmt_frame_engine.sv
module mgmt_frame_engine
  import mgmt_pkg::*;
#(
  parameter int FW       = FRAME_W,
  parameter int HALF     = HALF_CNT,
  parameter int RW       = REG_W,
  parameter int AW       = ADDR_W,
  parameter int OW       = OP_W,
  parameter int PHY_ADDR = 1,
  parameter int OP_READ  = 6,
  parameter int OP_WRITE = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step,
  input  logic           mdo,
  input  logic           dir,
  output logic           mdi_q,
  output logic [$clog2(FW+1)-1:0] cnt_q,
  output logic [AW-1:0]  rf_raddr,
  input  logic [RW-1:0]  rf_rdata,
  output logic           rf_we,
  output logic [AW-1:0]  rf_waddr,
  output logic [RW-1:0]  rf_wdata
);
  localparam int CNT_W = $clog2(FW + 1);
  localparam logic [CNT_W-1:0] FULL_C  = CNT_W'(FW);
  localparam logic [CNT_W-1:0] HALF_C  = CNT_W'(HALF);
  localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(FW - 1);
  localparam logic [CNT_W-1:0] PRE_H_C = CNT_W'(HALF - 1);
  localparam logic [AW-1:0]    PHY_C   = AW'(PHY_ADDR);
  localparam logic [OW-1:0]    RD_C    = OW'(OP_READ);
  localparam logic [OW-1:0]    WR_C    = OW'(OP_WRITE);

  logic [FW-1:0]    word_q;
  logic [FW-1:0]    word_sh;
  logic [FW-1:0]    word_nx;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_nx;
  logic             shift_bit;
  logic             preamble;
  logic             at_half;
  logic             at_full;
  logic             mdi_nx;
  logic             rd_cmd;
  logic             wr_cmd;

  always_comb begin
    cnt_inc   = (cnt_q == FULL_C) ? FULL_C : cnt_q + 1'b1;
    shift_bit = mdo & ((cnt_inc < HALF_C) | ~dir);
    word_sh   = {word_q[FW-2:0], shift_bit};
    preamble  = &word_sh;
    at_half   = (cnt_q == PRE_H_C);
    at_full   = (cnt_q == LAST_C);
    rd_cmd    = at_half & ~preamble & (word_sh[RD_OP_LSB +: OW] == RD_C);
    wr_cmd    = at_full & ~preamble & (word_sh[WR_OP_LSB +: OW] == WR_C)
                & (word_sh[WR_PHY_LSB +: AW] == PHY_C);
    rf_raddr  = word_sh[RD_REG_LSB +: AW];
    rf_waddr  = word_sh[WR_REG_LSB +: AW];
    rf_wdata  = word_sh[RW-1:0];
    rf_we     = step & wr_cmd;
    mdi_nx    = ((cnt_inc >= HALF_C) & dir) ? word_sh[HALF-1] : mdi_q;
    cnt_nx    = preamble ? '0 : cnt_inc;
    word_nx   = word_sh;
    if (rd_cmd) begin
      word_nx = (word_sh[RD_PHY_LSB +: AW] == PHY_C)
                ? {{(FW-RW){1'b0}}, rf_rdata} : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      cnt_q  <= '0;
      mdi_q  <= 1'b0;
    end else if (step) begin
      word_q <= word_nx;
      cnt_q  <= cnt_nx;
      mdi_q  <= mdi_nx;
    end
  end
endmodule

// File: rtl/mgmt_bitbang_phy.sv
module mgmt_bitbang_phy
  import mgmt_pkg::*;
#(
  parameter int CW       = CTRL_W,
  parameter int FW       = FRAME_W,
  parameter int RW       = REG_W,
  parameter int RN       = REG_N,
  parameter int PHY_ADDR = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] rd_data
);
  localparam int AW    = $clog2(RN);
  localparam int CNT_W = $clog2(FW + 1);

  logic [CW-1:0]    ctrl_q;
  logic             step;
  logic             mdo;
  logic             dir;
  logic             mdi_q;
  logic [CNT_W-1:0] cnt_w;
  logic [AW-1:0]    rf_raddr;
  logic [RW-1:0]    rf_rdata;
  logic             rf_we;
  logic [AW-1:0]    rf_waddr;
  logic [RW-1:0]    rf_wdata;

  mgmt_ctrl_reg #(.CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .step(step), .mdo(mdo), .dir(dir)
  );

  mgmt_frame_engine #(.FW(FW), .RW(RW), .AW(AW), .PHY_ADDR(PHY_ADDR)) u_eng (
    .clk(clk), .rst(rst), .step(step), .mdo(mdo), .dir(dir),
    .mdi_q(mdi_q), .cnt_q(cnt_w),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
  );

  mgmt_phy_regfile #(.RW(RW), .RN(RN), .AW(AW)) u_rf (
    .clk(clk), .rst(rst), .raddr(rf_raddr), .rdata(rf_rdata),
    .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata)
  );

  always_comb begin
    rd_data = ctrl_q;
    rd_data[MDI_BIT] = mdi_q;
  end
endmodule

// File: rtl/mgmt_bitbang_chk.sv
module mgmt_bitbang_chk
  import mgmt_pkg::*;
#(
  parameter int CW    = CTRL_W,
  parameter int FW    = FRAME_W,
  parameter int CNT_W = $clog2(FRAME_W + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [CW-1:0]    wr_data,
  input logic [CW-1:0]    rd_data,
  input logic [CNT_W-1:0] bit_cnt
);
  localparam logic [CW-1:0]    KEEP = ~(CW'(1) << MDI_BIT);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FW);

  logic no_rise;
  assign no_rise = wr_en & ~(wr_data[MDC_BIT] & ~rd_data[MDC_BIT]);

  p_wr_copy_r1: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((rd_data & KEEP) == ($past(wr_data) & KEEP)));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (rd_data == $past(rd_data)));

  p_no_rise_cnt_r3: assert property (@(posedge clk) disable iff (rst)
    no_rise |=> $stable(bit_cnt));

  p_no_rise_mdi_r3: assert property (@(posedge clk) disable iff (rst)
    no_rise |=> $stable(rd_data[MDI_BIT]));

  p_dir_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[DIR_BIT]) |=> $stable(rd_data[MDI_BIT]));

  p_cnt_sat_r11: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= FULL);
endmodule

bind mgmt_bitbang_phy mgmt_bitbang_chk #(.CW(CW), .FW(FW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .bit_cnt(cnt_w)
);

// File: tb/sim_mgmt_bitbang_phy.sv
`timescale 1ns/1ps
module sim_mgmt_bitbang_phy;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  bit cmp_on = 0;
  int junk = 0;

  // behavioural reference
  logic [31:0] m_ctrl;
  logic [31:0] m_word;
  bit          m_mdi;
  int          m_cnt;
  int          m_regs [32];
  bit          got [33];

  always #2.5 clk = ~clk;

  mgmt_bitbang_phy u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data));

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read();
    logic [31:0] v;
    v = m_ctrl;
    v[19] = m_mdi;
    return v;
  endfunction

  always @(negedge clk) begin
    if (cmp_on && !done) check(rd_data == m_read(), "R1 R2 R3 per-cycle readback", rd_data, m_read());
  end

  task automatic model_reset();
    m_ctrl = '0; m_word = '0; m_mdi = 0; m_cnt = 0;
    for (int i = 0; i < 32; i++) m_regs[i] = 0;
    m_regs[0] = 'h3100; m_regs[1] = 'hF02C; m_regs[2] = 'h7810;
    m_regs[4] = 'h0501; m_regs[5] = 'h4181; m_regs[14] = 'h3800;
    m_regs[16] = 'h0003; m_regs[17] = 'h0600; m_regs[18] = 'h0001;
  endtask

  task automatic model_write(input logic [31:0] d);
    bit rise, sb, last;
    int nc;
    rise = d[16] && !m_ctrl[16];
    m_ctrl = d;
    m_ctrl[19] = 1'b0;
    if (rise) begin
      last = (m_cnt == 31);
      nc = (m_cnt >= 32) ? 32 : m_cnt + 1;
      sb = d[17] && (nc < 16 || !d[18]);
      m_word = {m_word[30:0], sb};
      if (nc >= 16 && d[18]) m_mdi = m_word[15];
      if (m_word == 32'hFFFF_FFFF) m_cnt = 0;
      else begin
        m_cnt = nc;
        if (nc == 16 && m_word[15:12] == 4'd6)
          m_word = (m_word[11:7] == 5'd1) ? 32'(m_regs[m_word[6:2]]) : 32'd0;
        else if (last && m_word[31:28] == 4'd5 && m_word[27:23] == 5'd1)
          m_regs[m_word[22:18]] = int'(m_word[15:0]);
      end
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(posedge clk);
    #1 model_write(d);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    wr_en = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // one management clock; junk fills other bits and toggles bit 19 (R1, R2)
  task automatic mclk(input bit mdo, input bit dir, input bit dup);
    junk++;
    wr({12'h0, junk[0], dir, mdo, 1'b0, 16'(junk * 16'h3B5)});
    wr({12'h0, ~junk[0], dir, mdo, 1'b1, 16'(junk * 16'h71)});
    if (dup) wr({12'h0, junk[1], dir, ~mdo, 1'b1, 16'h0F0F}); // R3 no rising edge
    @(negedge clk);
  endtask

  task automatic preamble();
    for (int i = 0; i < 32; i++) mclk(1'b1, 1'b0, 1'b0);
  endtask

  task automatic send(input logic [31:0] v, input bit dir_hi, input bit dup);
    for (int i = 1; i <= 32; i++) begin
      mclk(v[32-i], dir_hi && i >= 16, dup);
      got[i] = rd_data[19];
    end
  endtask

  task automatic read_reg(input int phy, input int rg, output logic [14:0] val);
    preamble();
    send({4'b0110, 5'(phy), 5'(rg), 2'b00, 16'h0000}, 1'b1, 1'b0);
    check(got[16] == 1'b0, "R7 return bit after clock 16", 32'(got[16]), 0);
    for (int k = 17; k <= 31; k++) val[31-k] = got[k];
  endtask

  task automatic write_reg(input int phy, input int rg, input logic [15:0] d, input bit dir_hi, input bit dup);
    preamble();
    send({4'b0101, 5'(phy), 5'(rg), 2'b10, d}, dir_hi, dup);
  endtask

  task automatic expect_reg(input int rg, input logic [15:0] exp, input string tag);
    logic [14:0] v;
    read_reg(1, rg, v);
    check(v == exp[14:0], tag, 32'(v), 32'(exp[14:0]));
  endtask

  initial begin
    logic [14:0] v;
    model_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rd_data == 32'h0, "R1 reset readback", rd_data, 0);
    cmp_on = 1;
    // R10 R6 R7 reset values returned serially
    expect_reg(0, 16'h3100, "R10 R6 reg0 default");
    expect_reg(1, 16'hF02C, "R10 R7 reg1 default");
    expect_reg(2, 16'h7810, "R10 reg2 default");
    expect_reg(4, 16'h0501, "R10 reg4 default");
    expect_reg(5, 16'h4181, "R10 reg5 default");
    expect_reg(14, 16'h3800, "R10 reg14 default");
    expect_reg(17, 16'h0600, "R10 reg17 default");
    expect_reg(9, 16'h0000, "R10 reg9 zero");
    // R8 write then read back, with duplicate high writes (R3)
    write_reg(1, 3, 16'hBEEF, 1'b0, 1'b1);
    expect_reg(3, 16'hBEEF, "R8 R3 write reg3");
    // R9 other address: write ignored, read gives zero
    write_reg(2, 3, 16'h1234, 1'b0, 1'b0);
    expect_reg(3, 16'hBEEF, "R9 foreign write ignored");
    read_reg(2, 1, v);
    check(v == 15'h0, "R9 foreign read zero", 32'(v), 0);
    // R4 direction set during write drops data bits
    write_reg(1, 6, 16'h7FFF, 1'b1, 1'b0);
    expect_reg(6, 16'h0000, "R4 dir set drops data");
    write_reg(1, 6, 16'h2AD5, 1'b0, 1'b0);
    expect_reg(6, 16'h2AD5, "R4 dir clear shifts data");
    // R11 second command without preamble is ignored
    write_reg(1, 7, 16'h1111, 1'b0, 1'b0);
    send({4'b0101, 5'd1, 5'd7, 2'b10, 16'h5555}, 1'b0, 1'b0);
    expect_reg(7, 16'h1111, "R11 saturated no decode");
    // R5 preamble after saturation restores decode
    send({4'b0101, 5'd1, 5'd7, 2'b10, 16'h6666}, 1'b0, 1'b0);
    write_reg(1, 7, 16'h0C3A, 1'b0, 1'b0);
    expect_reg(7, 16'h0C3A, "R5 preamble restarts frame");
    idle(4);
    check(rd_data == m_read(), "R2 idle hold", rd_data, m_read());
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R1 actual=%h expected=%h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule